// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small load/store processor whose datapath shares one bus. It does not hold its sequence in hardwired state logic. It keeps a micro-state register and reads every control word from a table. The table index is the current micro-state, the 6-bit instruction opcode and two status bits: the zero flag from the datapath and the memory busy flag. Each table row supplies the full control bundle for the current cycle and the micro-state for the next cycle. Opcode dispatch, memory wait loops and the branch test are all rows of the same table.

The microcode covers instruction fetch and these instruction classes: register-register ALU, ALU with immediate, word load, jump, and branch-if-zero. An opcode outside these classes ends in a halt state, and only reset leaves that state. The control outputs are combinational functions of the registered micro-state and the live status inputs. The micro-state advances on each rising clock edge.

Top module: `ucode_seq`

## Requirements
- R1: While rst_n is low, the micro-state is forced to the first fetch step. The first control word after reset is therefore en_reg=1, reg_sel=3 and ld_ma=1, with every other control 0.
- R2: Fetch takes four steps, each setting only the controls listed, with every other control 0. The reg_sel codes are 0=rs, 1=rt, 2=rd, 3=PC. The alu_op codes are 0=none, 1=A+4, 2=A+B, 3=function field, 4=immediate-opcode op, 5=jump target.
  - Step 1: en_reg, reg_sel=3, ld_ma.
  - Step 2: en_reg, reg_sel=3, ld_a.
  - Step 3: en_mem, ld_ir.
  - Step 4: en_alu, alu_op=1, reg_wr, reg_sel=3.
- R3: In a step that reads memory (fetch step 3 and the last load step), the micro-state holds while busy=1. In that cycle en_mem stays 1 and ld_ir and reg_wr are 0. The step completes in the first cycle with busy=0.
- R4: After fetch step 4, the opcode selects the next sequence:
  - 6'h00 selects the ALU sequence.
  - 6'b001xxx selects the ALU-immediate sequence.
  - 6'h23 selects the load sequence.
  - 6'h02 selects the jump sequence.
  - 6'h04 selects the branch sequence.
- R5: The ALU sequence has three steps, then returns to fetch:
  - Step 1: en_reg, reg_sel=0, ld_a.
  - Step 2: en_reg, reg_sel=1, ld_b.
  - Step 3: en_alu, alu_op=3, reg_wr, reg_sel=2.
- R6: The ALU-immediate sequence has three steps, then returns to fetch. ext_sel codes: 0=sign-extended 16-bit, 1=sign-extended and shifted left by 2, 2=26-bit jump field.
  - Step 1: en_reg, reg_sel=0, ld_a.
  - Step 2: en_imm, ext_sel=0, ld_b.
  - Step 3: en_alu, alu_op=4, reg_wr, reg_sel=1.
- R7: The load sequence has four steps, then returns to fetch:
  - Step 1: A from rs.
  - Step 2: en_imm, ext_sel=0, ld_b.
  - Step 3: en_alu, alu_op=2, ld_ma.
  - Step 4: en_mem, reg_sel=1, reg_wr.
- R8: The jump sequence has three steps, then returns to fetch:
  - Step 1: en_reg, reg_sel=3, ld_a.
  - Step 2: en_imm, ext_sel=2, ld_b.
  - Step 3: en_alu, alu_op=5, reg_wr, reg_sel=3.
- R9: The branch sequence has two steps:
  - Step 1: A from rs.
  - Step 2: no controls. If zero=1, three taken steps follow; otherwise the sequencer returns to fetch.
  - Taken steps: en_reg with reg_sel=3 and ld_a; then en_imm with ext_sel=1 and ld_b; then en_alu with alu_op=2, reg_wr and reg_sel=3.
- R10: Any other opcode leads to a halt state. In that state every control output is 0, and the sequencer stays there until reset.
- R11: No table row, for any state, opcode or status value, drives more than one of en_imm, en_alu, en_reg, en_mem.
- R12: mem_wr is 0 in every table row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | Datapath flag: A register is zero |
| busy | input | 1 | Memory access not yet complete |
| ld_ir | output | 1 | Load instruction register from bus |
| ld_a | output | 1 | Load A operand register from bus |
| ld_b | output | 1 | Load B operand register from bus |
| ld_ma | output | 1 | Load memory address register from bus |
| en_imm | output | 1 | Immediate extender drives the bus |
| en_alu | output | 1 | ALU drives the bus |
| en_reg | output | 1 | Register file drives the bus |
| en_mem | output | 1 | Memory drives the bus |
| reg_wr | output | 1 | Register file write strobe |
| mem_wr | output | 1 | Memory write strobe |
| reg_sel | output | 2 | Register index source: 0 rs, 1 rt, 2 rd, 3 PC |
| ext_sel | output | 2 | Immediate form: 0 sext16, 1 sext16<<2, 2 jump field |
| alu_op | output | 3 | ALU operation: 0 none, 1 A+4, 2 A+B, 3 func, 4 imm-op, 5 jump target |

## Verification
The control word for a step depends only on the registered micro-state and the live opcode, zero and busy inputs. It is therefore valid in the same cycle as those inputs, and the next step appears one rising edge later. The bench drives inputs on the falling edge and compares all 17 control bits 2 ns later. It advances its behavioural model on the rising edge, so each comparison covers exactly one step, including held busy cycles and the branch decision. Rule R11 and rule R12 are checked separately by sweeping every table address through a second instance of the table with no clock involved.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    localparam int STATE_W = 5;
    localparam int OP_W    = 6;
    localparam int STAT_W  = 2;
    localparam int ADDR_W  = STATE_W + OP_W + STAT_W;
    localparam int SEL_W   = 2;
    localparam int ALU_W   = 3;

    typedef enum logic [STATE_W-1:0] {
        S_F0, S_F1, S_F2, S_F3,
        S_ALU0, S_ALU1, S_ALU2,
        S_ALI0, S_ALI1, S_ALI2,
        S_LW0, S_LW1, S_LW2, S_LW3,
        S_J0, S_J1, S_J2,
        S_BZ0, S_BZ1,
        S_BT0, S_BT1, S_BT2,
        S_HALT
    } state_e;

    localparam logic [SEL_W-1:0] RS_RS = 2'd0;
    localparam logic [SEL_W-1:0] RS_RT = 2'd1;
    localparam logic [SEL_W-1:0] RS_RD = 2'd2;
    localparam logic [SEL_W-1:0] RS_PC = 2'd3;

    localparam logic [SEL_W-1:0] EX_SEXT = 2'd0;
    localparam logic [SEL_W-1:0] EX_SHL2 = 2'd1;
    localparam logic [SEL_W-1:0] EX_JFLD = 2'd2;

    localparam logic [ALU_W-1:0] AO_NONE  = 3'd0;
    localparam logic [ALU_W-1:0] AO_INC4  = 3'd1;
    localparam logic [ALU_W-1:0] AO_ADD   = 3'd2;
    localparam logic [ALU_W-1:0] AO_FUNC  = 3'd3;
    localparam logic [ALU_W-1:0] AO_IMMOP = 3'd4;
    localparam logic [ALU_W-1:0] AO_JTARG = 3'd5;

    localparam logic [OP_W-1:0] OPC_ALU  = 6'h00;
    localparam logic [OP_W-1:0] OPC_J    = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQZ = 6'h04;
    localparam logic [OP_W-1:0] OPC_LW   = 6'h23;
    localparam logic [2:0]      OPC_ALUI_HI = 3'b001;

    typedef struct packed {
        logic             ld_ir;
        logic             ld_a;
        logic             ld_b;
        logic             ld_ma;
        logic             en_imm;
        logic             en_alu;
        logic             en_reg;
        logic             en_mem;
        logic             reg_wr;
        logic             mem_wr;
        logic [SEL_W-1:0] reg_sel;
        logic [SEL_W-1:0] ext_sel;
        logic [ALU_W-1:0] alu_op;
    } ctrl_t;

endpackage

// File: rtl/ucode_addr.sv
module ucode_addr
    import ucode_pkg::*;
(
    input  logic [STATE_W-1:0] state_i,
    input  logic [OP_W-1:0]    opcode_i,
    input  logic               zero_i,
    input  logic               busy_i,
    output logic [ADDR_W-1:0]  addr_o
);
    // Table index: state in the top bits, then opcode, then zero, then busy.
    always_comb begin
        addr_o = {state_i, opcode_i, zero_i, busy_i};
    end
endmodule

// File: rtl/ucode_rom.sv
module ucode_rom
    import ucode_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output ctrl_t             ctrl_o,
    output state_e            next_o
);
    state_e           st;
    logic [OP_W-1:0]  op;
    logic             z;
    logic             b;

    always_comb begin
        st = state_e'(addr_i[ADDR_W-1 -: STATE_W]);
        op = addr_i[STAT_W +: OP_W];
        z  = addr_i[1];
        b  = addr_i[0];
    end

    // Every row of the control store is computed here from the index fields.
    always_comb begin
        ctrl_o = '0;
        next_o = S_HALT;
        unique case (st)
            S_F0: begin
                ctrl_o.en_reg = 1'b1; ctrl_o.reg_sel = RS_PC; ctrl_o.ld_ma = 1'b1;
                next_o = S_F1;
            end
            S_F1: begin
                ctrl_o.en_reg = 1'b1; ctrl_o.reg_sel = RS_PC; ctrl_o.ld_a = 1'b1;
                next_o = S_F2;
            end
            S_F2: begin
                ctrl_o.en_mem = 1'b1; ctrl_o.ld_ir = !b;
                next_o = b ? S_F2 : S_F3;
            end
            S_F3: begin
                ctrl_o.en_alu = 1'b1; ctrl_o.alu_op = AO_INC4;
                ctrl_o.reg_wr = 1'b1; ctrl_o.reg_sel = RS_PC;
                if (op == OPC_ALU)                     next_o = S_ALU0;
                else if (op[OP_W-1 -: 3] == OPC_ALUI_HI) next_o = S_ALI0;
                else if (op == OPC_LW)                 next_o = S_LW0;
                else if (op == OPC_J)                  next_o = S_J0;
                else if (op == OPC_BEQZ)               next_o = S_BZ0;
                else                                   next_o = S_HALT;
            end
            S_ALU0, S_ALI0, S_LW0, S_BZ0: begin
                ctrl_o.en_reg = 1'b1; ctrl_o.reg_sel = RS_RS; ctrl_o.ld_a = 1'b1;
                unique case (st)
                    S_ALU0:  next_o = S_ALU1;
                    S_ALI0:  next_o = S_ALI1;
                    S_LW0:   next_o = S_LW1;
                    default: next_o = S_BZ1;
                endcase
            end
            S_ALU1: begin
                ctrl_o.en_reg = 1'b1; ctrl_o.reg_sel = RS_RT; ctrl_o.ld_b = 1'b1;
                next_o = S_ALU2;
            end
            S_ALU2: begin
                ctrl_o.en_alu = 1'b1; ctrl_o.alu_op = AO_FUNC;
                ctrl_o.reg_wr = 1'b1; ctrl_o.reg_sel = RS_RD;
                next_o = S_F0;
            end
            S_ALI1, S_LW1: begin
                ctrl_o.en_imm = 1'b1; ctrl_o.ext_sel = EX_SEXT; ctrl_o.ld_b = 1'b1;
                next_o = (st == S_ALI1) ? S_ALI2 : S_LW2;
            end
            S_ALI2: begin
                ctrl_o.en_alu = 1'b1; ctrl_o.alu_op = AO_IMMOP;
                ctrl_o.reg_wr = 1'b1; ctrl_o.reg_sel = RS_RT;
                next_o = S_F0;
            end
            S_LW2: begin
                ctrl_o.en_alu = 1'b1; ctrl_o.alu_op = AO_ADD; ctrl_o.ld_ma = 1'b1;
                next_o = S_LW3;
            end
            S_LW3: begin
                ctrl_o.en_mem = 1'b1; ctrl_o.reg_sel = RS_RT; ctrl_o.reg_wr = !b;
                next_o = b ? S_LW3 : S_F0;
            end
            S_J0, S_BT0: begin
                ctrl_o.en_reg = 1'b1; ctrl_o.reg_sel = RS_PC; ctrl_o.ld_a = 1'b1;
                next_o = (st == S_J0) ? S_J1 : S_BT1;
            end
            S_J1: begin
                ctrl_o.en_imm = 1'b1; ctrl_o.ext_sel = EX_JFLD; ctrl_o.ld_b = 1'b1;
                next_o = S_J2;
            end
            S_J2: begin
                ctrl_o.en_alu = 1'b1; ctrl_o.alu_op = AO_JTARG;
                ctrl_o.reg_wr = 1'b1; ctrl_o.reg_sel = RS_PC;
                next_o = S_F0;
            end
            S_BZ1: begin
                next_o = z ? S_BT0 : S_F0;
            end
            S_BT1: begin
                ctrl_o.en_imm = 1'b1; ctrl_o.ext_sel = EX_SHL2; ctrl_o.ld_b = 1'b1;
                next_o = S_BT2;
            end
            S_BT2: begin
                ctrl_o.en_alu = 1'b1; ctrl_o.alu_op = AO_ADD;
                ctrl_o.reg_wr = 1'b1; ctrl_o.reg_sel = RS_PC;
                next_o = S_F0;
            end
            default: begin
                ctrl_o = '0;
                next_o = S_HALT;
            end
        endcase
    end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import ucode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    input  logic             zero,
    input  logic             busy,
    output logic             ld_ir,
    output logic             ld_a,
    output logic             ld_b,
    output logic             ld_ma,
    output logic             en_imm,
    output logic             en_alu,
    output logic             en_reg,
    output logic             en_mem,
    output logic             reg_wr,
    output logic             mem_wr,
    output logic [SEL_W-1:0] reg_sel,
    output logic [SEL_W-1:0] ext_sel,
    output logic [ALU_W-1:0] alu_op
);
    typedef struct packed {
        state_e st;
    } seq_regs_t;

    seq_regs_t         seq_d, seq_q;
    logic [ADDR_W-1:0] rom_addr;
    ctrl_t             rom_ctrl;
    state_e            rom_next;

    ucode_addr u_addr (
        .state_i  (seq_q.st),
        .opcode_i (opcode),
        .zero_i   (zero),
        .busy_i   (busy),
        .addr_o   (rom_addr)
    );

    ucode_rom u_rom (
        .addr_i (rom_addr),
        .ctrl_o (rom_ctrl),
        .next_o (rom_next)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.st = rom_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: S_F0};
        else        seq_q <= seq_d;
    end

    assign ld_ir   = rom_ctrl.ld_ir;
    assign ld_a    = rom_ctrl.ld_a;
    assign ld_b    = rom_ctrl.ld_b;
    assign ld_ma   = rom_ctrl.ld_ma;
    assign en_imm  = rom_ctrl.en_imm;
    assign en_alu  = rom_ctrl.en_alu;
    assign en_reg  = rom_ctrl.en_reg;
    assign en_mem  = rom_ctrl.en_mem;
    assign reg_wr  = rom_ctrl.reg_wr;
    assign mem_wr  = rom_ctrl.mem_wr;
    assign reg_sel = rom_ctrl.reg_sel;
    assign ext_sel = rom_ctrl.ext_sel;
    assign alu_op  = rom_ctrl.alu_op;

    // R1: the first sampled state after reset release is the first fetch step
    a_r1_reset_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> seq_q.st == S_F0);

    // R2: fetch step 1 is always followed by fetch step 2
    a_r2_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.st == S_F0 |=> seq_q.st == S_F1);

    // R3: memory-read steps hold while busy
    a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == S_F2 || seq_q.st == S_LW3) && busy) |=> seq_q.st == $past(seq_q.st));

    // R3: no load or write strobe while memory data is not ready
    a_r3_no_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && en_mem) |-> (!ld_ir && !reg_wr));

    // R9: untaken branch returns to fetch
    a_r9_untaken: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == S_BZ1 && !zero) |=> seq_q.st == S_F0);

    // R10: halt is sticky and drives nothing
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.st == S_HALT |=> (seq_q.st == S_HALT && !en_imm && !en_alu && !en_reg && !en_mem));

    // R11: at most one bus driver per cycle
    a_r11_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({en_imm, en_alu, en_reg, en_mem}) <= 1);

    // R12: memory write strobe never raised
    a_r12_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr);
endmodule

// File: tb/ucode_seq_bench.sv
module ucode_seq_bench;
    import ucode_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       zero = 1'b0;
    logic       busy = 1'b0;
    logic       ld_ir, ld_a, ld_b, ld_ma, en_imm, en_alu, en_reg, en_mem, reg_wr, mem_wr;
    logic [1:0] reg_sel, ext_sel;
    logic [2:0] alu_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ucode_seq u_ucode_seq (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero), .busy(busy),
        .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma),
        .en_imm(en_imm), .en_alu(en_alu), .en_reg(en_reg), .en_mem(en_mem),
        .reg_wr(reg_wr), .mem_wr(mem_wr), .reg_sel(reg_sel), .ext_sel(ext_sel),
        .alu_op(alu_op)
    );

    // Second copy of the table, swept through its index port
    logic [ADDR_W-1:0] probe_addr = '0;
    ctrl_t             probe_ctrl;
    state_e            probe_next;
    ucode_rom u_rom_probe (.addr_i(probe_addr), .ctrl_o(probe_ctrl), .next_o(probe_next));

    // Model phases
    localparam int P_FMA = 0, P_FPC = 1, P_FIR = 2, P_FINC = 3;
    localparam int P_AR_A = 4, P_AR_B = 5, P_AR_W = 6;
    localparam int P_AI_A = 7, P_AI_B = 8, P_AI_W = 9;
    localparam int P_LD_A = 10, P_LD_B = 11, P_LD_M = 12, P_LD_W = 13;
    localparam int P_JP_A = 14, P_JP_B = 15, P_JP_W = 16;
    localparam int P_BR_A = 17, P_BR_T = 18;
    localparam int P_TK_A = 19, P_TK_B = 20, P_TK_W = 21;
    localparam int P_STOP = 22;

    int ph = P_FMA;

    function automatic logic [16:0] word(input bit ir, la, lb, lm, ei, ea, er, em, rw,
                                         input int rs, es, ao);
        logic [1:0] rsv = rs[1:0];
        logic [1:0] esv = es[1:0];
        logic [2:0] aov = ao[2:0];
        return {ir, la, lb, lm, ei, ea, er, em, rw, 1'b0, rsv, esv, aov};
    endfunction

    function automatic logic [16:0] expect_word(input int p, input logic b);
        case (p)
            P_FMA:                         return word(0,0,0,1, 0,0,1,0, 0, 3,0,0);
            P_FPC, P_JP_A, P_TK_A:         return word(0,1,0,0, 0,0,1,0, 0, 3,0,0);
            P_FIR:                         return word(!b,0,0,0, 0,0,0,1, 0, 0,0,0);
            P_FINC:                        return word(0,0,0,0, 0,1,0,0, 1, 3,0,1);
            P_AR_A, P_AI_A, P_LD_A, P_BR_A: return word(0,1,0,0, 0,0,1,0, 0, 0,0,0);
            P_AR_B:                        return word(0,0,1,0, 0,0,1,0, 0, 1,0,0);
            P_AR_W:                        return word(0,0,0,0, 0,1,0,0, 1, 2,0,3);
            P_AI_B, P_LD_B:                return word(0,0,1,0, 1,0,0,0, 0, 0,0,0);
            P_AI_W:                        return word(0,0,0,0, 0,1,0,0, 1, 1,0,4);
            P_LD_M:                        return word(0,0,0,1, 0,1,0,0, 0, 0,0,2);
            P_LD_W:                        return word(0,0,0,0, 0,0,0,1, !b, 1,0,0);
            P_JP_B:                        return word(0,0,1,0, 1,0,0,0, 0, 0,2,0);
            P_JP_W:                        return word(0,0,0,0, 0,1,0,0, 1, 3,0,5);
            P_TK_B:                        return word(0,0,1,0, 1,0,0,0, 0, 0,1,0);
            P_TK_W:                        return word(0,0,0,0, 0,1,0,0, 1, 3,0,2);
            default:                       return '0;
        endcase
    endfunction

    function automatic int step_next(input int p, input logic [5:0] op, input logic z, input logic b);
        if (p == P_FIR) return b ? P_FIR : P_FINC;
        if (p == P_LD_W) return b ? P_LD_W : P_FMA;
        if (p == P_FINC) begin
            if (op == 6'h00) return P_AR_A;
            if (op >= 6'h08 && op <= 6'h0F) return P_AI_A;
            if (op == 6'h23) return P_LD_A;
            if (op == 6'h02) return P_JP_A;
            if (op == 6'h04) return P_BR_A;
            return P_STOP;
        end
        if (p == P_BR_T) return z ? P_TK_A : P_FMA;
        if (p == P_AR_W || p == P_AI_W || p == P_JP_W || p == P_TK_W) return P_FMA;
        if (p == P_STOP) return P_STOP;
        return p + 1;
    endfunction

    function automatic string tag_of(input int p);
        if (p <= P_FINC) return "R2";
        if (p <= P_AR_W) return "R5";
        if (p <= P_AI_W) return "R6";
        if (p <= P_LD_W) return "R7";
        if (p <= P_JP_W) return "R8";
        if (p <= P_TK_W) return "R9";
        return "R10";
    endfunction

    task automatic compare(input string tag, input logic [16:0] exp_w);
        logic [16:0] act;
        act = {ld_ir, ld_a, ld_b, ld_ma, en_imm, en_alu, en_reg, en_mem, reg_wr, mem_wr,
               reg_sel, ext_sel, alu_op};
        checks++;
        if (act !== exp_w) begin
            errors++;
            $display("FAIL %s phase=%0d actual=%b expected=%b", tag, ph, act, exp_w);
        end
    endtask

    // One clock: inputs already driven after the falling edge
    task automatic one_cycle(input string tag);
        #2;
        compare(tag, expect_word(ph, busy));
        @(posedge clk);
        ph = step_next(ph, opcode, zero, busy);
        @(negedge clk);
    endtask

    task automatic run_instr(input logic [5:0] op, input logic z, input int fetch_wait, input int load_wait);
        int fw = fetch_wait;
        int lw = load_wait;
        opcode = op;
        zero   = z;
        do begin
            busy = 1'b0;
            if (ph == P_FIR && fw > 0) begin busy = 1'b1; fw--; end
            if (ph == P_LD_W && lw > 0) begin busy = 1'b1; lw--; end
            // R3: held memory steps are tagged as busy checks
            if (busy) one_cycle("R3");
            else if (ph == P_FINC) one_cycle("R4");
            else one_cycle(tag_of(ph));
        end while (ph != P_FMA && ph != P_STOP);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        // R11 and R12: every table row
        begin
            int bad11 = 0;
            int bad12 = 0;
            for (int a = 0; a < (1 << ADDR_W); a++) begin
                probe_addr = a[ADDR_W-1:0];
                #1;
                if ($countones({probe_ctrl.en_imm, probe_ctrl.en_alu,
                                probe_ctrl.en_reg, probe_ctrl.en_mem}) > 1) begin
                    if (bad11 == 0)
                        $display("FAIL R11 addr=%0d actual=%0d drivers expected<=1", a,
                                 $countones({probe_ctrl.en_imm, probe_ctrl.en_alu,
                                             probe_ctrl.en_reg, probe_ctrl.en_mem}));
                    bad11++;
                end
                if (probe_ctrl.mem_wr !== 1'b0) begin
                    if (bad12 == 0)
                        $display("FAIL R12 addr=%0d actual=%b expected=0", a, probe_ctrl.mem_wr);
                    bad12++;
                end
            end
            checks += 2;
            if (bad11 != 0) errors++;
            if (bad12 != 0) errors++;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        #2;
        compare("R1", word(0,0,0,1, 0,0,1,0, 0, 3,0,0));
        @(negedge clk);
        rst_n = 1'b1;
        ph = P_FMA;

        run_instr(6'h00, 1'b0, 0, 0);   // R5
        run_instr(6'h0C, 1'b0, 2, 0);   // R6 with fetch wait (R3)
        run_instr(6'h23, 1'b0, 1, 3);   // R7 with both waits (R3)
        run_instr(6'h02, 1'b0, 0, 0);   // R8
        run_instr(6'h04, 1'b1, 0, 0);   // R9 taken
        run_instr(6'h04, 1'b0, 0, 0);   // R9 untaken
        run_instr(6'h08, 1'b0, 0, 0);   // R4 lower ALU-immediate code
        run_instr(6'h23, 1'b0, 0, 0);   // R7 without wait
        run_instr(6'h3F, 1'b0, 1, 0);   // R10 unknown opcode

        // R10: halt persists under any inputs
        opcode = 6'h00; zero = 1'b1; busy = 1'b1;
        for (int i = 0; i < 4; i++) one_cycle("R10");
        busy = 1'b0;

        // R1: reset from halt
        rst_n = 1'b0;
        #2;
        compare("R1", word(0,0,0,1, 0,0,1,0, 0, 3,0,0));
        @(negedge clk);
        rst_n = 1'b1;
        ph = P_FMA;
        run_instr(6'h02, 1'b0, 0, 0);   // R8 after reset

        done = 1'b1;
        finish_run();
    end
endmodule